// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from normal execution into an exception handler. It accepts three fault requests: an undefined instruction, an instruction-fetch protection fault and a data-access protection fault. It resolves them by a fixed priority. On acceptance it captures the current status word, the address of the faulting instruction and the system stack pointer. It then reports the status word with the user-mode and stack-select bits cleared. This moves the core into privilege mode on the system stack.

The sequence then runs three memory transfers through a single-outstanding request/acknowledge port. The status word goes to the descending system stack first and the faulting address second. Each push lowers the stack pointer by one step. Last, the handler address is read from a vector slot located relative to a table base input.

A debug-break input turns protection faults into a break event with no stack activity. A data protection fault that arrives while the return-from-exception path is accessing memory parks the block in a halted state. It leaves that state only on reset or on a break interrupt.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, and after a reset taken in the middle of a sequence, `busy`, `done`, `mem_req`, `halted` and `brk_evt` are 0 and `cause` is 0.
- R2: When requests coincide, data protection wins over instruction protection, which wins over undefined instruction. `cause` reports 1 for undefined instruction, 2 for instruction protection and 3 for data protection, from the cycle after acceptance.
- R3: The first transfer is a write (`mem_we`=1) to the captured stack pointer minus STEP, carrying the status word exactly as it was sampled at acceptance.
- R4: The second transfer is a write to the captured stack pointer minus twice STEP, carrying the faulting instruction address (`fault_pc`) sampled at acceptance.
- R5: The third transfer is a read (`mem_we`=0) from the table base plus 0x3C4 (undefined), 0x3E4 (instruction protection) or 0x3E0 (data protection), modulo 2^AW. Stack addresses also wrap modulo 2^AW.
- R6: One cycle after the vector read is acknowledged, `done` is high for exactly one cycle, `new_pc` equals the read data, `ssp_out` equals the captured stack pointer minus twice STEP, and `busy` is low.
- R7: From the cycle after acceptance, `ps_out` equals the captured status word with bit UM_BIT (user mode) and bit S_BIT (stack select) cleared.
- R8: While `mem_req` is high and `mem_ack` is low, the request, address, write data and direction hold unchanged, and the sequence does not advance.
- R9: `busy` is high from the cycle after acceptance until `done` rises. New requests during that time are ignored and do not change `cause`.
- R10: With `dbg_break_en` high, a winning protection fault gives a one-cycle `brk_evt` and no sequence: `busy` and `mem_req` stay low.
- R11: A data protection fault with `reti_active` high and `dbg_break_en` low sets `halted`. While halted, no request starts a sequence or memory transfer. `brk_irq` clears `halted` and pulses `brk_evt` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_undef | input | 1 | Undefined-instruction fault request |
| req_iprot | input | 1 | Instruction-fetch protection fault request |
| req_dprot | input | 1 | Data-access protection fault request |
| dbg_break_en | input | 1 | Debugger asks for protection faults to become breaks |
| reti_active | input | 1 | Return-from-exception path is accessing memory |
| brk_irq | input | 1 | Break interrupt, the only exit from the halted state |
| fault_pc | input | AW | Address of the faulting instruction |
| ps_in | input | DW | Current status word |
| ssp_in | input | AW | Current system stack pointer |
| tbr_in | input | AW | Vector table base |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Transfer address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Transfer acknowledge |
| mem_rdata | input | DW | Read data, valid with acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse, new PC valid |
| cause | output | 2 | Code of the accepted fault |
| new_pc | output | AW | Handler address read from the vector slot |
| ssp_out | output | AW | Stack pointer after the pushes |
| ps_out | output | DW | Status word with privilege and stack-select forced |
| brk_evt | output | 1 | One-cycle break event |
| halted | output | 1 | Double-fault halt state |

## Verification
The bench builds the block with AW and DW both set to 16 and keeps the default STEP, bit positions and vector offsets. The 16-bit address space makes wrap-around cheap to reach. A stack pointer of 4 drives the second push below zero, to 0xFFFC. A table base of 0xFD00 carries the vector slot past the top of memory. Both show that the address arithmetic stays modulo 2^AW. A table of request mixes covers each priority pair and each acknowledge delay, and directed runs cover the break, halt and mid-sequence reset paths.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_UNDEF = 2'd1,
        CAUSE_IPROT = 2'd2,
        CAUSE_DPROT = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_PS = 3'd1,
        ST_PUSH_PC = 3'd2,
        ST_VEC_RD  = 3'd3,
        ST_HALT    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/exc_req_arb.sv
module exc_req_arb
    import exc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int VEC_UNDEF = 32'h3C4,
    parameter int VEC_IPROT = 32'h3E4,
    parameter int VEC_DPROT = 32'h3E0
) (
    input  logic          enable,
    input  logic          req_undef,
    input  logic          req_iprot,
    input  logic          req_dprot,
    input  logic          dbg_break_en,
    input  logic          reti_active,
    output logic          take,
    output logic          brk,
    output logic          halt_go,
    output cause_e        cause,
    output logic [AW-1:0] vec_off
);

    always_comb begin
        take    = 1'b0;
        brk     = 1'b0;
        halt_go = 1'b0;
        cause   = CAUSE_NONE;
        if (enable) begin
            if (req_dprot) begin
                cause = CAUSE_DPROT;
                if (dbg_break_en)     brk     = 1'b1;
                else if (reti_active) halt_go = 1'b1;
                else                  take    = 1'b1;
            end else if (req_iprot) begin
                cause = CAUSE_IPROT;
                if (dbg_break_en) brk  = 1'b1;
                else              take = 1'b1;
            end else if (req_undef) begin
                cause = CAUSE_UNDEF;
                take  = 1'b1;
            end
        end
    end

    always_comb begin
        case (cause)
            CAUSE_DPROT: vec_off = AW'(VEC_DPROT);
            CAUSE_IPROT: vec_off = AW'(VEC_IPROT);
            default:     vec_off = AW'(VEC_UNDEF);
        endcase
    end

    // R2: at most one action is chosen per cycle
    always_comb begin
        p_one_action_r2: assert ($onehot0({take, brk, halt_go}))
            else $error("arbiter chose more than one action");
    end

endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] ssp_cur,
    input  logic [AW-1:0] tbr,
    input  logic [AW-1:0] vec_off,
    output logic [AW-1:0] push_addr,
    output logic [AW-1:0] vec_addr
);

    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    always_comb begin
        push_addr = ssp_cur - STEP_W;
        vec_addr  = tbr + vec_off;
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int STEP      = 4,
    parameter int UM_BIT    = 11,
    parameter int S_BIT     = 5,
    parameter int VEC_UNDEF = 32'h3C4,
    parameter int VEC_IPROT = 32'h3E4,
    parameter int VEC_DPROT = 32'h3E0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_undef,
    input  logic          req_iprot,
    input  logic          req_dprot,
    input  logic          dbg_break_en,
    input  logic          reti_active,
    input  logic          brk_irq,
    input  logic [AW-1:0] fault_pc,
    input  logic [DW-1:0] ps_in,
    input  logic [AW-1:0] ssp_in,
    input  logic [AW-1:0] tbr_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    cause,
    output logic [AW-1:0] new_pc,
    output logic [AW-1:0] ssp_out,
    output logic [DW-1:0] ps_out,
    output logic          brk_evt,
    output logic          halted
);

    localparam logic [DW-1:0] PRIV_MASK = (DW'(1) << UM_BIT) | (DW'(1) << S_BIT);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] ssp;
        logic [DW-1:0] ps;
        logic [AW-1:0] pc;
        logic [AW-1:0] vaddr;
        cause_e        cause;
        logic          done;
        logic          brk;
        logic [AW-1:0] npc;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic          arb_take, arb_brk, arb_halt;
    cause_e        arb_cause;
    logic [AW-1:0] arb_off;
    logic [AW-1:0] push_addr, vec_addr;

    exc_req_arb #(
        .AW(AW), .VEC_UNDEF(VEC_UNDEF), .VEC_IPROT(VEC_IPROT), .VEC_DPROT(VEC_DPROT)
    ) i_arb (
        .enable       (r_q.st == ST_IDLE),
        .req_undef    (req_undef),
        .req_iprot    (req_iprot),
        .req_dprot    (req_dprot),
        .dbg_break_en (dbg_break_en),
        .reti_active  (reti_active),
        .take         (arb_take),
        .brk          (arb_brk),
        .halt_go      (arb_halt),
        .cause        (arb_cause),
        .vec_off      (arb_off)
    );

    exc_addr_gen #(.AW(AW), .STEP(STEP)) i_addr (
        .ssp_cur   (r_q.ssp),
        .tbr       (tbr_in),
        .vec_off   (arb_off),
        .push_addr (push_addr),
        .vec_addr  (vec_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.brk  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (arb_halt) begin
                    r_d.st = ST_HALT;
                end else if (arb_brk) begin
                    r_d.brk = 1'b1;
                end else if (arb_take) begin
                    r_d.st    = ST_PUSH_PS;
                    r_d.ssp   = ssp_in;
                    r_d.ps    = ps_in;
                    r_d.pc    = fault_pc;
                    r_d.vaddr = vec_addr;
                    r_d.cause = arb_cause;
                end
            end
            ST_PUSH_PS: begin
                if (mem_ack) begin
                    r_d.ssp = push_addr;
                    r_d.st  = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: begin
                if (mem_ack) begin
                    r_d.ssp = push_addr;
                    r_d.st  = ST_VEC_RD;
                end
            end
            ST_VEC_RD: begin
                if (mem_ack) begin
                    r_d.npc  = AW'(mem_rdata);
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (brk_irq) begin
                    r_d.st  = ST_IDLE;
                    r_d.brk = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_req   = (r_q.st == ST_PUSH_PS) || (r_q.st == ST_PUSH_PC) || (r_q.st == ST_VEC_RD);
        mem_we    = (r_q.st == ST_PUSH_PS) || (r_q.st == ST_PUSH_PC);
        mem_addr  = (r_q.st == ST_VEC_RD) ? r_q.vaddr : push_addr;
        mem_wdata = (r_q.st == ST_PUSH_PS) ? r_q.ps : DW'(r_q.pc);
        busy      = mem_req;
        done      = r_q.done;
        cause     = r_q.cause;
        new_pc    = r_q.npc;
        ssp_out   = r_q.ssp;
        ps_out    = r_q.ps & ~PRIV_MASK;
        brk_evt   = r_q.brk;
        halted    = (r_q.st == ST_HALT);
    end

    // R8: a pending transfer holds still until acknowledged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy is already low when done rises
    p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: no memory activity while halted
    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !busy));

    // R10: a break event never starts a sequence
    p_brk_no_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |-> (!busy && !mem_req));

endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam logic [15:0] MASK = 16'h0820; // UM bit 11, S bit 5 (R7)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_undef = 0, req_iprot = 0, req_dprot = 0;
    logic dbg_break_en = 0, reti_active = 0, brk_irq = 0;
    logic [AW-1:0] fault_pc = '0, ssp_in = '0, tbr_in = '0;
    logic [DW-1:0] ps_in = '0, mem_rdata = '0;
    logic mem_ack = 0;
    logic mem_req, mem_we, busy, done, brk_evt, halted;
    logic [AW-1:0] mem_addr, new_pc, ssp_out;
    logic [DW-1:0] mem_wdata, ps_out;
    logic [1:0] cause;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    exc_entry_seq #(.AW(AW), .DW(DW)) i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .req_undef(req_undef), .req_iprot(req_iprot), .req_dprot(req_dprot),
        .dbg_break_en(dbg_break_en), .reti_active(reti_active), .brk_irq(brk_irq),
        .fault_pc(fault_pc), .ps_in(ps_in), .ssp_in(ssp_in), .tbr_in(tbr_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .cause(cause), .new_pc(new_pc),
        .ssp_out(ssp_out), .ps_out(ps_out), .brk_evt(brk_evt), .halted(halted)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input logic [1:0] c);
        case (c)
            2'd3:    return 16'h03E0;
            2'd2:    return 16'h03E4;
            default: return 16'h03C4;
        endcase
    endfunction

    typedef struct packed {
        logic [2:0]  reqs;   // {dprot, iprot, undef}
        logic [15:0] ps;
        logic [15:0] pc;
        logic [15:0] ssp;
        logic [15:0] tbr;
        logic [15:0] rdata;
        logic [3:0]  wait_n;
        logic [1:0]  ecause;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3'b001, 16'hFFFF, 16'h1234, 16'h8000, 16'h0000, 16'hABCD, 4'd0, 2'd1},
        '{3'b010, 16'h0820, 16'h2000, 16'h4010, 16'h1000, 16'h5A5A, 4'd2, 2'd2},
        '{3'b100, 16'h7F3C, 16'h0FFE, 16'h2222, 16'h2000, 16'h0101, 4'd1, 2'd3},
        '{3'b111, 16'h1357, 16'h3456, 16'h6000, 16'h3000, 16'hBEEF, 4'd0, 2'd3},
        '{3'b011, 16'hF0F0, 16'h4444, 16'h7000, 16'h4000, 16'hC0DE, 4'd3, 2'd2},
        '{3'b110, 16'h0001, 16'h5550, 16'h1000, 16'h0100, 16'h7777, 4'd0, 2'd3},
        '{3'b001, 16'hAAAA, 16'hFFF0, 16'h0004, 16'hFD00, 16'h4321, 4'd2, 2'd1}
    };

    task automatic run_vec(input vec_t v);
        logic [15:0] e1, e2, ev;
        e1 = v.ssp - 16'd4;
        e2 = v.ssp - 16'd8;
        ev = v.tbr + vec_of(v.ecause);
        @(negedge clk);
        {req_dprot, req_iprot, req_undef} = v.reqs;
        ps_in = v.ps; fault_pc = v.pc; ssp_in = v.ssp; tbr_in = v.tbr;
        @(negedge clk);
        {req_dprot, req_iprot, req_undef} = 3'b000;
        chk(busy === 1'b1, "R9", "busy after accept", 32'(busy), 1);
        chk(cause === v.ecause, "R2", "cause", 32'(cause), 32'(v.ecause));
        chk(ps_out === (v.ps & ~MASK), "R7", "ps_out", 32'(ps_out), 32'(v.ps & ~MASK));
        chk(mem_req && mem_we && mem_addr === e1, "R3", "first push addr", 32'(mem_addr), 32'(e1));
        chk(mem_wdata === v.ps, "R3", "first push data", 32'(mem_wdata), 32'(v.ps));
        req_dprot = 1'b1; // spurious request while busy (R9)
        ssp_in = 16'h0BAD; ps_in = 16'h0BAD;
        for (int k = 0; k < int'(v.wait_n); k++) begin
            @(negedge clk);
            chk(mem_req && mem_we && mem_addr === e1 && mem_wdata === v.ps, "R8",
                "hold without ack", 32'(mem_addr), 32'(e1));
        end
        mem_ack = 1'b1;
        @(negedge clk);
        chk(mem_req && mem_we && mem_addr === e2, "R4", "second push addr", 32'(mem_addr), 32'(e2));
        chk(mem_wdata === v.pc, "R4", "second push data", 32'(mem_wdata), 32'(v.pc));
        @(negedge clk);
        chk(mem_req && !mem_we && mem_addr === ev, "R5", "vector read addr", 32'(mem_addr), 32'(ev));
        mem_rdata = v.rdata;
        req_dprot = 1'b0;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R6", "done/busy", 32'({done, busy}), 32'h2);
        chk(new_pc === v.rdata, "R6", "new_pc", 32'(new_pc), 32'(v.rdata));
        chk(ssp_out === e2, "R6", "ssp_out", 32'(ssp_out), 32'(e2));
        chk(cause === v.ecause, "R9", "cause kept despite later request", 32'(cause), 32'(v.ecause));
        @(negedge clk);
        chk(done === 1'b0 && mem_req === 1'b0, "R6", "done one cycle", 32'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, done, mem_req, halted, brk_evt} === 5'b0 && cause === 2'd0, "R1",
            "reset outputs", 32'({busy, done, mem_req, halted, brk_evt, cause}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 7; i++) run_vec(VECS[i]);

        // R10: debug break on instruction protection
        @(negedge clk);
        dbg_break_en = 1'b1; req_iprot = 1'b1;
        @(negedge clk);
        req_iprot = 1'b0;
        chk(brk_evt === 1'b1 && busy === 1'b0 && mem_req === 1'b0, "R10", "iprot break",
            32'({brk_evt, busy, mem_req}), 32'h4);
        // R10: debug break on data protection, even with reti_active
        req_dprot = 1'b1; reti_active = 1'b1;
        @(negedge clk);
        req_dprot = 1'b0; reti_active = 1'b0; dbg_break_en = 1'b0;
        chk(brk_evt === 1'b1 && halted === 1'b0 && mem_req === 1'b0, "R10", "dprot break",
            32'({brk_evt, halted, mem_req}), 32'h4);
        @(negedge clk);
        chk(brk_evt === 1'b0 && busy === 1'b0, "R10", "break one cycle", 32'({brk_evt, busy}), 0);

        // R11: data fault during return path halts
        req_dprot = 1'b1; reti_active = 1'b1;
        @(negedge clk);
        req_dprot = 1'b0; reti_active = 1'b0;
        chk(halted === 1'b1 && mem_req === 1'b0 && busy === 1'b0, "R11", "enter halt",
            32'({halted, mem_req, busy}), 32'h4);
        req_undef = 1'b1; req_iprot = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(halted === 1'b1 && mem_req === 1'b0 && busy === 1'b0, "R11",
                "requests ignored in halt", 32'({halted, mem_req, busy}), 32'h4);
        end
        req_undef = 1'b0; req_iprot = 1'b0;
        brk_irq = 1'b1;
        @(negedge clk);
        brk_irq = 1'b0;
        chk(halted === 1'b0 && brk_evt === 1'b1, "R11", "break interrupt exits halt",
            32'({halted, brk_evt}), 32'h1);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        req_undef = 1'b1; ssp_in = 16'h3000; tbr_in = 16'h0;
        @(negedge clk);
        req_undef = 1'b0;
        chk(busy === 1'b1, "R1", "sequence started", 32'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, mem_req, halted, brk_evt} === 5'b0 && cause === 2'd0, "R1",
            "reset mid-sequence", 32'({busy, done, mem_req, halted, brk_evt, cause}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule